// File: doc/BRIEF.md
# SD Card Block Data Mover

This block sits between a processor-visible word window and a byte-wide card data path. Software programs a byte count, a start-bit timeout and a control word that picks the direction, the block size (as a power of two), DMA request use and the service threshold. Once enabled, the block moves bytes one per clock between a small word FIFO and the card side. After every block it stops and waits for that block's CRC verdict before it goes on.

Software or a DMA engine keeps the FIFO serviced. Two level flags tell it when to act. One says a read has words waiting. The other says a write has room and still owes data. Four sticky status bits record how the transfer ended: end of data, good CRC, bad CRC and start-bit timeout. They stay set until software writes ones to the clear address.

Top module: `sdx_data_engine`

## Requirements
- R1: Control word fields: bits [3:0] give log2 of the block size in bytes. Bit 4 selects write (1) or read (0). Bit 5 enables DMA requests. Bit 6 set starts a transfer. Bit 7 selects the half-depth service threshold (1) or the full-depth threshold (0). A control write with bit 6 clear stops a running transfer.
- R2: A control write with bit 8 set only empties the FIFO. It leaves the stored control word, the length and the sticky status untouched.
- R3: `depth_words` reports the FIFO depth in 32-bit words. The FIFO never holds more than that many words, and window writes to a full FIFO are dropped.
- R4: On a read, card bytes are packed little-endian (the first byte goes to bits [7:0]). A final partial word is zero-padded. Words are popped by `bus_rd` and appear on `bus_rdata`.
- R5: On a write, each FIFO word is sent least significant byte first. Exactly the programmed byte count is sent, and unused bytes of the last word are discarded.
- R6: Status bit 9 is high while a read is enabled and the FIFO holds at least the threshold number of words, or holds any word after the last byte has arrived.
- R7: Status bit 8 is high while a write is enabled, software still owes bytes and the free space is at least the threshold.
- R8: `dma_req` follows status bit 8 or bit 9 when control bit 5 is set, and is low otherwise.
- R9: On a read, if no card start arrives within timer+1 cycles of waiting for a block, status bit 3 is set and the transfer stops.
- R10: A good CRC verdict sets status bit 5. A bad verdict sets status bit 1 and stops the transfer without setting bit 7.
- R11: Status bit 7 is set after the last block's good CRC verdict. A zero byte count sets it at once.
- R12: Status bits 1, 3, 5 and 7 are sticky. A write to address 3 clears each one whose data bit is 1, and a new event in the same cycle wins. Register addresses: 0 control, 1 length, 2 timer, 3 clear, 4 data window.
- R13: After each block of 2^n bytes (or fewer, if it is the last), the mover waits for a CRC verdict. On a read it then waits for a new card start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Data window read (pop) strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | FIFO head word for window reads |
| status | output | 10 | Status flags (bits 1,3,5,7 sticky; 8,9 level) |
| depth_words | output | 8 | FIFO depth in words |
| dma_req | output | 1 | DMA service request |
| card_start | input | 1 | Card data start bit seen (read) |
| card_rx_valid | input | 1 | Card read byte valid |
| card_rx_byte | input | 8 | Card read byte |
| card_rx_ready | output | 1 | Mover accepts a read byte |
| card_tx_valid | output | 1 | Write byte valid toward card |
| card_tx_byte | output | 8 | Write byte toward card |
| card_tx_ready | input | 1 | Card accepts the write byte |
| card_crc_valid | input | 1 | Block CRC verdict strobe |
| card_crc_good | input | 1 | Block CRC verdict is good |

## Verification
A wrong byte counter shows on the card side within the same block. Extra or missing bytes appear on `card_tx_byte`, or the CRC wait begins at the wrong byte, which shifts every later word on `bus_rdata`. Wrong packing or a wrong byte lane shows as a mismatched word on the very first window read. A stuck sequencer state shows up as a missing end bit or a timeout bit a few cycles after the stimulus. A wrong FIFO count changes the service flags and `dma_req` in the cycle after the push or pop.

// File: rtl/sdx_pkg.sv
// Shared encodings for the SD block data mover.
// Assumes a single clock domain and a byte-per-cycle card interface.
package sdx_pkg;
    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_MOVE, S_CRC} sdx_state_e;

    localparam int CTL_WR    = 4;
    localparam int CTL_DMA   = 5;
    localparam int CTL_EN    = 6;
    localparam int CTL_HALF  = 7;
    localparam int CTL_FLUSH = 8;

    localparam int SB_BAD    = 1;
    localparam int SB_TMO    = 3;
    localparam int SB_GOOD   = 5;
    localparam int SB_END    = 7;
    localparam int SB_TXNEED = 8;
    localparam int SB_RXRDY  = 9;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_LEN  = 3'd1;
    localparam logic [2:0] A_TMR  = 3'd2;
    localparam logic [2:0] A_CLR  = 3'd3;
    localparam logic [2:0] A_WIN  = 3'd4;
endpackage

// File: rtl/sdx_word_fifo.sv
// Word FIFO with synchronous flush.
// Assumes DEPTH is a power of two; a push when full or a pop when empty is ignored.
module sdx_word_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rp];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= wp + AW'(1);
            if (pop_ok)  rp <= rp + AW'(1);
            if (push_ok && !pop_ok)      count <= count + CW'(1);
            else if (pop_ok && !push_ok) count <= count - CW'(1);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end
endmodule

// File: rtl/sdx_xfer_fsm.sv
// Block sequencer: counts bytes and blocks, waits for start bits and CRC
// verdicts, and packs or unpacks little-endian words for the FIFO.
// Assumes start and the configuration inputs are stable when start pulses.
module sdx_xfer_fsm
    import sdx_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             dir_wr,
    input  logic [3:0]       blk_log2,
    input  logic [LEN_W-1:0] length,
    input  logic [TMR_W-1:0] timer,
    input  logic             card_start,
    input  logic             card_rx_valid,
    input  logic [7:0]       card_rx_byte,
    output logic             card_rx_ready,
    output logic             card_tx_valid,
    output logic [7:0]       card_tx_byte,
    input  logic             card_tx_ready,
    input  logic             card_crc_valid,
    input  logic             card_crc_good,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    input  logic [31:0]      pop_data,
    output logic             push_word,
    output logic [31:0]      push_data,
    output logic             pop_word,
    output logic             ev_end,
    output logic             ev_crc_ok,
    output logic             ev_crc_fail,
    output logic             ev_timeout,
    output logic             bytes_done
);
    localparam int BLK_W = 16;

    sdx_state_e       state;
    logic [LEN_W-1:0] remain;
    logic [BLK_W-1:0] blk_left, blk_bytes;
    logic [TMR_W-1:0] tmr;
    logic [1:0]       bidx;
    logic [31:0]      pack;
    logic             fire, last_byte, blk_last;

    // Handshake, lane select and word boundary decode.
    always_comb begin
        blk_bytes     = BLK_W'(1) << blk_log2;
        last_byte     = (remain == LEN_W'(1));
        blk_last      = (blk_left == BLK_W'(1));
        card_rx_ready = (state == S_MOVE) && !dir_wr && !fifo_full;
        card_tx_valid = (state == S_MOVE) && dir_wr && !fifo_empty;
        card_tx_byte  = pop_data[{bidx, 3'b000} +: 8];
        fire          = dir_wr ? (card_tx_valid && card_tx_ready)
                               : (card_rx_ready && card_rx_valid);
        push_data     = pack | ({24'b0, card_rx_byte} << {bidx, 3'b000});
        push_word     = fire && !dir_wr && (bidx == 2'd3 || last_byte);
        pop_word      = fire && dir_wr && (bidx == 2'd3 || last_byte);
        bytes_done    = (remain == '0);
    end

    // Sequencer state, counters and completion events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            remain      <= '0;
            blk_left    <= '0;
            tmr         <= '0;
            bidx        <= '0;
            pack        <= '0;
            ev_end      <= 1'b0;
            ev_crc_ok   <= 1'b0;
            ev_crc_fail <= 1'b0;
            ev_timeout  <= 1'b0;
        end else begin
            ev_end      <= 1'b0;
            ev_crc_ok   <= 1'b0;
            ev_crc_fail <= 1'b0;
            ev_timeout  <= 1'b0;
            if (abort) begin
                state <= S_IDLE;
            end else if (start) begin
                remain   <= length;
                blk_left <= blk_bytes;
                tmr      <= timer;
                bidx     <= '0;
                pack     <= '0;
                if (length == '0) begin
                    ev_end <= 1'b1;
                    state  <= S_IDLE;
                end else begin
                    state <= dir_wr ? S_MOVE : S_WAIT;
                end
            end else begin
                case (state)
                    S_WAIT: begin
                        if (card_start) begin
                            state <= S_MOVE;
                        end else if (tmr == '0) begin
                            ev_timeout <= 1'b1;
                            state      <= S_IDLE;
                        end else begin
                            tmr <= tmr - TMR_W'(1);
                        end
                    end
                    S_MOVE: begin
                        if (fire) begin
                            remain   <= remain - LEN_W'(1);
                            blk_left <= blk_left - BLK_W'(1);
                            bidx     <= bidx + 2'd1;
                            pack     <= push_word ? '0 : push_data;
                            if (last_byte || blk_last) state <= S_CRC;
                        end
                    end
                    S_CRC: begin
                        if (card_crc_valid) begin
                            if (!card_crc_good) begin
                                ev_crc_fail <= 1'b1;
                                state       <= S_IDLE;
                            end else begin
                                ev_crc_ok <= 1'b1;
                                if (remain == '0) begin
                                    ev_end <= 1'b1;
                                    state  <= S_IDLE;
                                end else begin
                                    blk_left <= blk_bytes;
                                    tmr      <= timer;
                                    state    <= dir_wr ? S_MOVE : S_WAIT;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdx_data_engine.sv
// SD block data mover top: register decode, sticky status, service flags
// and steering between the data window, the FIFO and the sequencer.
// Assumes one register access per cycle and a power-of-two FIFO depth.
module sdx_data_engine
    import sdx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TMR_W = 16,
    parameter int LEN_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [9:0]  status,
    output logic [7:0]  depth_words,
    output logic        dma_req,
    input  logic        card_start,
    input  logic        card_rx_valid,
    input  logic [7:0]  card_rx_byte,
    output logic        card_rx_ready,
    output logic        card_tx_valid,
    output logic [7:0]  card_tx_byte,
    input  logic        card_tx_ready,
    input  logic        card_crc_valid,
    input  logic        card_crc_good
);
    localparam int CW = $clog2(DEPTH+1);

    logic [7:0]       ctrl_q;
    logic [LEN_W-1:0] len_q, owe_q;
    logic [TMR_W-1:0] tmr_q;
    logic [3:0]       sticky_q, clr_mask, set_mask;
    logic             start_q, abort_q;
    logic             dir_wr, wr_ctrl, flush, win_push, win_pop;
    logic             fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [31:0]      fifo_wdata, fifo_rdata, fsm_push_data;
    logic [CW-1:0]    fifo_count, free_words, thr_words;
    logic             fsm_push, fsm_pop, bytes_done;
    logic             ev_end, ev_good, ev_bad, ev_tmo;
    logic             rx_flag, tx_flag;

    // Access decode and FIFO steering by direction.
    always_comb begin
        dir_wr     = ctrl_q[CTL_WR];
        wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
        flush      = wr_ctrl && bus_wdata[CTL_FLUSH];
        win_push   = bus_wr && (bus_addr == A_WIN) && dir_wr && !fifo_full;
        win_pop    = bus_rd && !dir_wr;
        fifo_push  = dir_wr ? win_push : fsm_push;
        fifo_wdata = dir_wr ? bus_wdata : fsm_push_data;
        fifo_pop   = dir_wr ? fsm_pop : win_pop;
        clr_mask   = (bus_wr && bus_addr == A_CLR)
                   ? {bus_wdata[SB_END], bus_wdata[SB_GOOD], bus_wdata[SB_TMO], bus_wdata[SB_BAD]}
                   : 4'b0;
        set_mask   = {ev_end, ev_good, ev_tmo, ev_bad};
    end

    // Configuration registers, delayed start/stop and bytes owed by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            len_q   <= '0;
            tmr_q   <= '0;
            owe_q   <= '0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            start_q <= wr_ctrl && !flush && bus_wdata[CTL_EN];
            abort_q <= wr_ctrl && !flush && !bus_wdata[CTL_EN];
            if (wr_ctrl && !flush)                 ctrl_q <= bus_wdata[7:0];
            if (bus_wr && bus_addr == A_LEN)       len_q  <= bus_wdata[LEN_W-1:0];
            if (bus_wr && bus_addr == A_TMR)       tmr_q  <= bus_wdata[TMR_W-1:0];
            if (wr_ctrl && !flush && bus_wdata[CTL_EN])
                owe_q <= len_q;
            else if (win_push)
                owe_q <= (owe_q > LEN_W'(4)) ? owe_q - LEN_W'(4) : '0;
        end
    end

    // Sticky completion status; a new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~clr_mask) | set_mask;
    end

    // Service flags, DMA request and status assembly.
    always_comb begin
        thr_words   = ctrl_q[CTL_HALF] ? CW'(DEPTH/2) : CW'(DEPTH);
        free_words  = CW'(DEPTH) - fifo_count;
        rx_flag     = ctrl_q[CTL_EN] && !dir_wr &&
                      ((fifo_count >= thr_words) || (!fifo_empty && bytes_done));
        tx_flag     = ctrl_q[CTL_EN] && dir_wr && (owe_q != '0) &&
                      (free_words >= thr_words);
        dma_req     = ctrl_q[CTL_DMA] && (rx_flag || tx_flag);
        status            = '0;
        status[SB_BAD]    = sticky_q[0];
        status[SB_TMO]    = sticky_q[1];
        status[SB_GOOD]   = sticky_q[2];
        status[SB_END]    = sticky_q[3];
        status[SB_TXNEED] = tx_flag;
        status[SB_RXRDY]  = rx_flag;
        depth_words = 8'(DEPTH);
        bus_rdata   = fifo_rdata;
    end

    sdx_word_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    sdx_xfer_fsm #(.TMR_W(TMR_W), .LEN_W(LEN_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start_q),
        .abort          (abort_q),
        .dir_wr         (dir_wr),
        .blk_log2       (ctrl_q[3:0]),
        .length         (len_q),
        .timer          (tmr_q),
        .card_start     (card_start),
        .card_rx_valid  (card_rx_valid),
        .card_rx_byte   (card_rx_byte),
        .card_rx_ready  (card_rx_ready),
        .card_tx_valid  (card_tx_valid),
        .card_tx_byte   (card_tx_byte),
        .card_tx_ready  (card_tx_ready),
        .card_crc_valid (card_crc_valid),
        .card_crc_good  (card_crc_good),
        .fifo_full      (fifo_full),
        .fifo_empty     (fifo_empty),
        .pop_data       (fifo_rdata),
        .push_word      (fsm_push),
        .push_data      (fsm_push_data),
        .pop_word       (fsm_pop),
        .ev_end         (ev_end),
        .ev_crc_ok      (ev_good),
        .ev_crc_fail    (ev_bad),
        .ev_timeout     (ev_tmo),
        .bytes_done     (bytes_done)
    );
endmodule

// File: rtl/sdx_data_engine_chk.sv
// Property checker for the SD block data mover, attached by bind.
// Assumes the status bit layout given in the requirements.
module sdx_data_engine_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [9:0]                 status,
    input logic                       card_tx_valid,
    input logic                       card_rx_ready,
    input logic                       dir_wr,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count,
    input logic                       bus_wr,
    input logic [2:0]                 bus_addr,
    input logic [31:0]                bus_wdata
);
    logic clr7, clr1;
    assign clr7 = bus_wr && (bus_addr == 3'd3) && bus_wdata[7];
    assign clr1 = bus_wr && (bus_addr == 3'd3) && bus_wdata[1];

    assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_count) <= DEPTH);

    assert_tx_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_valid |-> dir_wr);

    assert_rx_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_ready |-> !dir_wr);

    assert_end_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !clr7) |=> status[7]);

    assert_fail_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !clr1) |=> status[1]);

    assert_fail_no_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> !$rose(status[7]));

    assert_timeout_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> !card_rx_ready);
endmodule

bind sdx_data_engine sdx_data_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .status        (status),
    .card_tx_valid (card_tx_valid),
    .card_rx_ready (card_rx_ready),
    .dir_wr        (ctrl_q[4]),
    .fifo_count    (fifo_count),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata)
);

// File: tb/tb_sdx_data_engine.sv
// Scoreboard bench: driver code queues expected words/bytes, monitor code
// pops and compares them as the mover produces them.
module tb_sdx_data_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  status;
    logic [7:0]  depth_words;
    logic        dma_req;
    logic        card_start = 1'b0, card_rx_valid = 1'b0;
    logic [7:0]  card_rx_byte = '0;
    logic        card_rx_ready, card_tx_valid;
    logic [7:0]  card_tx_byte;
    logic        card_tx_ready = 1'b1;
    logic        card_crc_valid = 1'b0, card_crc_good = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_words[$];
    logic [7:0]  exp_bytes[$];

    always #10 clk = ~clk;

    sdx_data_engine dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status(status), .depth_words(depth_words), .dma_req(dma_req),
        .card_start(card_start), .card_rx_valid(card_rx_valid),
        .card_rx_byte(card_rx_byte), .card_rx_ready(card_rx_ready),
        .card_tx_valid(card_tx_valid), .card_tx_byte(card_tx_byte),
        .card_tx_ready(card_tx_ready), .card_crc_valid(card_crc_valid),
        .card_crc_good(card_crc_good)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Card stub for a read block: start bit, bytes base.., CRC verdict.
    task automatic card_block(input int n, input logic [7:0] base, input bit good);
        @(negedge clk); card_start = 1'b1;
        @(negedge clk); card_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            card_rx_valid = 1'b1;
            card_rx_byte  = base + 8'(i);
            while (!card_rx_ready) @(negedge clk);
            @(negedge clk);
        end
        card_rx_valid  = 1'b0;
        card_crc_valid = 1'b1; card_crc_good = good;
        @(negedge clk);
        card_crc_valid = 1'b0;
    endtask

    // Monitor for read data: pop words when the read flag is up.
    task automatic sw_read(input int nwords, input string req);
        for (int k = 0; k < nwords; k++) begin
            @(negedge clk);
            while (!status[9]) @(negedge clk);
            chk(req, bus_rdata, exp_words.pop_front());
            bus_rd = 1'b1;
            @(negedge clk);
            bus_rd = 1'b0;
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11: run hung, actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk("R12 reset status", 32'(status), 32'h0);
        chk("R8 reset dma", 32'(dma_req), 32'h0);
        chk("R3 depth", 32'(depth_words), 32'd4);
        chk("R5 reset tx", 32'(card_tx_valid), 32'h0);

        // Read: 16 bytes, 8-byte blocks, full threshold, no DMA (R1 R4 R6 R11 R13).
        bus_write(3'd1, 32'd16);
        bus_write(3'd2, 32'd50);
        for (int w = 0; w < 4; w++)
            exp_words.push_back({8'h13 + 8'(4*w), 8'h12 + 8'(4*w), 8'h11 + 8'(4*w), 8'h10 + 8'(4*w)});
        bus_write(3'd0, 32'h43);
        fork
            begin card_block(8, 8'h10, 1'b1); card_block(8, 8'h18, 1'b1); end
            begin
                @(negedge clk);
                while (!status[9]) @(negedge clk);
                chk("R8 dma off", 32'(dma_req), 32'h0);
                sw_read(4, "R4 read word");
            end
        join
        @(negedge clk);
        chk("R11 end after read", 32'(status[7]), 32'h1);
        chk("R10 crc ok", 32'(status[5]), 32'h1);

        // Clear sticky bits.
        bus_write(3'd3, 32'hAA);
        @(negedge clk);
        chk("R12 clear", 32'(status), 32'h0);

        // Write: 10 bytes, 4-byte blocks, half threshold (R1 R5 R7 R13).
        bus_write(3'd1, 32'd10);
        bus_write(3'd0, 32'hD2);
        @(negedge clk);
        chk("R7 need data", 32'(status[8]), 32'h1);
        for (int b = 0; b < 10; b++) exp_bytes.push_back(8'hA0 + 8'(b));
        fork
            begin
                logic [31:0] words [3];
                words[0] = 32'hA3A2A1A0; words[1] = 32'hA7A6A5A4; words[2] = 32'hFFFFA9A8;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    while (!status[8]) @(negedge clk);
                    bus_write(3'd4, words[k]);
                end
            end
            begin
                int n;
                n = 0;
                @(negedge clk);
                while (n < 10) begin
                    if (card_tx_valid) begin
                        chk("R5 tx byte", 32'(card_tx_byte), 32'(exp_bytes.pop_front()));
                        n++;
                        if (n == 4 || n == 8 || n == 10) begin
                            @(negedge clk); card_crc_valid = 1'b1; card_crc_good = 1'b1;
                            @(negedge clk); card_crc_valid = 1'b0;
                        end else @(negedge clk);
                    end else @(negedge clk);
                end
            end
        join
        repeat (3) @(negedge clk);
        chk("R11 end after write", 32'(status[7]), 32'h1);
        chk("R5 no extra byte", 32'(card_tx_valid), 32'h0);
        chk("R7 no more owed", 32'(status[8]), 32'h0);

        // Zero length (R11).
        bus_write(3'd3, 32'hAA);
        bus_write(3'd1, 32'd0);
        bus_write(3'd0, 32'h40);
        repeat (2) @(negedge clk);
        chk("R11 zero length end", 32'(status[7]), 32'h1);
        chk("R10 zero length no crc", 32'(status[5]), 32'h0);

        // Timeout (R9).
        bus_write(3'd3, 32'hAA);
        bus_write(3'd1, 32'd8);
        bus_write(3'd2, 32'd5);
        bus_write(3'd0, 32'h43);
        repeat (15) @(negedge clk);
        chk("R9 timeout set", 32'(status[3]), 32'h1);
        chk("R9 no end", 32'(status[7]), 32'h0);
        chk("R9 stopped", 32'(card_rx_ready), 32'h0);

        // Bad CRC on 3-byte read with DMA (R4 R6 R8 R10).
        bus_write(3'd3, 32'hAA);
        bus_write(3'd1, 32'd3);
        bus_write(3'd2, 32'd50);
        bus_write(3'd0, 32'h62);
        card_block(3, 8'h11, 1'b0);
        @(negedge clk);
        chk("R10 crc fail", 32'(status[1]), 32'h1);
        chk("R10 no end", 32'(status[7]), 32'h0);
        chk("R6 partial ready", 32'(status[9]), 32'h1);
        chk("R8 dma on", 32'(dma_req), 32'h1);
        exp_words.push_back(32'h00131211);
        sw_read(1, "R4 padded word");
        @(negedge clk);
        chk("R6 drained", 32'(status[9]), 32'h0);
        chk("R8 dma drop", 32'(dma_req), 32'h0);

        // Two 2-byte blocks then flush (R13 R2).
        bus_write(3'd3, 32'hAA);
        bus_write(3'd1, 32'd4);
        bus_write(3'd0, 32'h41);
        card_block(2, 8'h44, 1'b1);
        chk("R13 waits for start", 32'(card_rx_ready), 32'h0);
        chk("R13 not ended", 32'(status[7]), 32'h0);
        card_block(2, 8'h46, 1'b1);
        @(negedge clk);
        chk("R6 word ready", 32'(status[9]), 32'h1);
        chk("R13 end", 32'(status[7]), 32'h1);
        chk("R4 packed word", bus_rdata, 32'h47464544);
        bus_write(3'd0, 32'h100);
        @(negedge clk);
        chk("R2 fifo flushed", 32'(status[9]), 32'h0);
        chk("R2 status kept", 32'(status[7]), 32'h1);

        summary();
        $finish;
    end
endmodule